// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block is a small data cache between a processor request port and a block-wide memory port. It keeps two ways per set. The request address is split into a tag, a set index and a byte offset. Both stored tags of the indexed set are compared in parallel. The read word is then steered out of the matching way, so returned data only becomes meaningful once the hit decision is known.

Writes update only the cache and mark the line dirty. Memory sees a line only when that line is evicted. A one-bit pointer per set names the way to replace next. It is moved to point away from whichever way was last used, both on a hit and on a refill.

On a miss the controller first writes back a dirty victim as one full block. It then reads the new block, installs it, and looks the request up again. A write miss therefore modifies the word only after the whole block has arrived. The processor holds its request until `cpu_done` pulses.

Top module: `lru2_cache`

## Requirements
- R1: With the default parameters (32-bit byte address, 4 sets, 4 words of 32 bits per block), address bits [3:2] pick the word in the block, bits [5:4] pick the set, and bits [31:6] form the tag. `mem_addr` carries the block address, which is the byte address shifted right by 4.
- R2: A hit accepted in the lookup state raises `cpu_done` on the very next cycle, with no memory request. For a read, `cpu_rdata` holds the latest value written to that address.
- R3: A write hit changes only the cached word and marks the line dirty. It causes no memory transaction.
- R4: A miss whose victim way is invalid or clean performs exactly one block read and no block write. `cpu_done` rises 4 cycles after the request when memory answers 2 cycles after its request.
- R5: A miss whose victim is valid and dirty first writes the full victim block, including every cached update, to the victim's block address. It then performs one block read.
- R6: The victim is the way named by the set's pointer. A hit or a refill makes the pointer name the other way.
- R7: On a write miss the block is fetched before the addressed word is changed. The other words of the block keep their memory values, and a later eviction writes back the merged block.
- R8: A synchronous reset invalidates every line, clears every dirty bit and every pointer, and leaves `cpu_done` and `mem_req` low. Data that was dirty at reset is never written back.
- R9: `cpu_done` is a single-cycle pulse. A memory request keeps `mem_we` and `mem_addr` stable until `mem_ready`.
- R10: A completed write-back is followed directly by a read request for the missing block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid while cpu_done is high |
| cpu_done | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | 28 | Block address |
| mem_wdata | output | 128 | Victim block |
| mem_rdata | input | 128 | Refill block |
| mem_ready | input | 1 | Memory completes the transfer this cycle |

## Verification
The bench aims at the replacement pointer. It touches one way, then misses in the same set. A design that did not move the pointer on hits would evict the recently used line, and the following access would show an unexpected refill. Dirty evictions are checked by comparing the written block with the bench's value of every word. A design that forgot a write hit, or merged a write miss before the refill, would write back a stale or corrupted block. A reset with dirty lines present must discard them: a later read has to return the old memory value with no write-back. A long pseudo-random sweep over eight tags and all sets then checks read data, transfer counts, transfer addresses and exact latency against a bench model.

// File: rtl/lru2_cache.sv
module lru2_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int WORDS  = 4
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         cpu_req,
  input  logic                                         cpu_we,
  input  logic [ADDR_W-1:0]                            cpu_addr,
  input  logic [DATA_W-1:0]                            cpu_wdata,
  output logic [DATA_W-1:0]                            cpu_rdata,
  output logic                                         cpu_done,
  output logic                                         mem_req,
  output logic                                         mem_we,
  output logic [ADDR_W-$clog2(WORDS*DATA_W/8)-1:0]     mem_addr,
  output logic [DATA_W*WORDS-1:0]                      mem_wdata,
  input  logic [DATA_W*WORDS-1:0]                      mem_rdata,
  input  logic                                         mem_ready
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BYTE_W = $clog2(DATA_W/8);
  localparam int OFF_W  = WSEL_W + BYTE_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W  = DATA_W * WORDS;

  typedef enum logic [1:0] {LOOKUP, WRITEBACK, REFILL, RESPOND} st_t;
  st_t state;

  logic [BLK_W-1:0] dat   [2][SETS];
  logic [TAG_W-1:0] tags  [2][SETS];
  logic             valid [2][SETS];
  logic             dirty [2][SETS];
  logic             lru   [SETS];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  logic              hit0, hit1, hit, hway, victim;

  assign idx  = cpu_addr[OFF_W +: IDX_W];
  assign tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign wsel = cpu_addr[BYTE_W +: WSEL_W];
  wire unused_low = &{1'b0, cpu_addr[BYTE_W-1:0]};

  assign hit0   = valid[0][idx] && (tags[0][idx] == tag);
  assign hit1   = valid[1][idx] && (tags[1][idx] == tag);
  assign hit    = hit0 | hit1;
  assign hway   = hit1;
  assign victim = lru[idx];

  assign cpu_rdata = dat[hway][idx][wsel*DATA_W +: DATA_W];
  assign cpu_done  = (state == RESPOND);
  assign mem_req   = (state == WRITEBACK) || (state == REFILL);
  assign mem_we    = (state == WRITEBACK);
  assign mem_addr  = (state == WRITEBACK) ? {tags[victim][idx], idx} : {tag, idx};
  assign mem_wdata = dat[victim][idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LOOKUP;
      for (int s = 0; s < SETS; s++) begin
        lru[s] <= 1'b0;
        for (int w = 0; w < 2; w++) begin
          valid[w][s] <= 1'b0;
          dirty[w][s] <= 1'b0;
        end
      end
    end else begin
      case (state)
        LOOKUP:
          if (cpu_req) begin
            if (hit)                                    state <= RESPOND;
            else if (valid[victim][idx] && dirty[victim][idx]) state <= WRITEBACK;
            else                                        state <= REFILL;
          end
        WRITEBACK:
          if (mem_ready) begin
            dirty[victim][idx] <= 1'b0;
            state <= REFILL;
          end
        REFILL:
          if (mem_ready) begin
            dat[victim][idx]   <= mem_rdata;
            tags[victim][idx]  <= tag;
            valid[victim][idx] <= 1'b1;
            dirty[victim][idx] <= 1'b0;
            lru[idx]           <= ~victim;
            state <= LOOKUP;
          end
        RESPOND: begin
          lru[idx] <= ~hway;
          if (cpu_we) begin
            dat[hway][idx][wsel*DATA_W +: DATA_W] <= cpu_wdata;
            dirty[hway][idx] <= 1'b1;
          end
          state <= LOOKUP;
        end
        default: state <= LOOKUP;
      endcase
    end
  end
endmodule

// File: rtl/lru2_cache_chk.sv
module lru2_cache_chk #(
  parameter int MA_W = 28
) (
  input logic            clk,
  input logic            rst,
  input logic            cpu_done,
  input logic            mem_req,
  input logic            mem_we,
  input logic [MA_W-1:0] mem_addr,
  input logic            mem_ready,
  input logic            hit
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  p_wb_then_read_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we));

  p_done_no_mem_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !mem_req);

  p_refill_hits_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ready) |=> hit);
endmodule

bind lru2_cache lru2_cache_chk u_chk (
  .clk(clk), .rst(rst), .cpu_done(cpu_done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready), .hit(hit)
);

// File: tb/sim_lru2_cache.sv
module sim_lru2_cache;
  logic         clk = 0, rst = 1;
  logic         cpu_req = 0, cpu_we = 0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_done, mem_req, mem_we;
  logic [27:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 0;

  lru2_cache u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [127:0] mem [32];
  logic [31:0]  gold [32][4];
  int  stag [2][4];
  bit  sval [2][4], sdirt [2][4];
  int  slru [4];
  int  wb_cnt = 0, rf_cnt = 0, mcnt = 0;
  logic [27:0]  last_wb_addr;
  logic [127:0] last_wb_data;
  int  last_lat, last_rf, last_wb;
  logic [31:0] last_rd;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic prev;
    prev = mem_ready;
    mem_ready = 0;
    if (mem_req && !prev) begin
      mcnt++;
      if (mcnt == 2) begin
        mcnt = 0;
        mem_ready = 1;
        if (mem_we) begin
          mem[mem_addr[4:0]] = mem_wdata;
          wb_cnt++;
          last_wb_addr = mem_addr;
          last_wb_data = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[4:0]];
          rf_cnt++;
        end
      end
    end
  end

  task automatic model_clear();
    for (int s = 0; s < 4; s++) begin
      slru[s] = 0;
      for (int w = 0; w < 2; w++) begin sval[w][s] = 0; sdirt[w][s] = 0; stag[w][s] = 0; end
    end
    for (int b = 0; b < 32; b++)
      for (int w = 0; w < 4; w++) gold[b][w] = mem[b][w*32 +: 32];
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; cpu_req = 0;
    @(negedge clk); @(negedge clk);
    chk(!cpu_done && !mem_req, "R8 reset idle", {cpu_done, mem_req}, 0);
    rst = 0;
    model_clear();
  endtask

  task automatic access(input logic we, input int tg, input int ix, input int wd, input logic [31:0] wdat);
    int blk, way, v, exp_lat, wb0, rf0, vb;
    bit exp_wb;
    logic [127:0] expblk;
    blk = tg*4 + ix;
    way = -1;
    for (int w = 0; w < 2; w++) if (sval[w][ix] && stag[w][ix] == tg) way = w;
    v = slru[ix];
    exp_wb = (way < 0) && sval[v][ix] && sdirt[v][ix];
    vb = stag[v][ix]*4 + ix;
    for (int w = 0; w < 4; w++) expblk[w*32 +: 32] = gold[vb][w];
    exp_lat = (way >= 0) ? 1 : (exp_wb ? 7 : 4);
    wb0 = wb_cnt; rf0 = rf_cnt;
    cpu_we = we; cpu_wdata = wdat;
    cpu_addr = (32'(tg) << 6) | (32'(ix) << 4) | (32'(wd) << 2);
    cpu_req = 1;
    last_lat = 0;
    do begin
      @(negedge clk); last_lat++;
    end while (!cpu_done && last_lat < 100);
    if (last_lat >= 100) chk(0, "R9 watchdog", last_lat, exp_lat);
    last_rd = cpu_rdata;
    cpu_req = 0;
    @(negedge clk);
    last_rf = rf_cnt - rf0; last_wb = wb_cnt - wb0;
    chk(last_lat == exp_lat, (way >= 0) ? "R2 hit latency" : "R4 miss latency", last_lat, exp_lat);
    chk(last_rf == ((way < 0) ? 1 : 0), "R4 refill count", last_rf, (way < 0));
    chk(last_wb == int'(exp_wb), "R5 writeback count", last_wb, exp_wb);
    if (exp_wb && last_wb == 1) begin
      chk(last_wb_addr == 28'(vb), "R10 writeback address", last_wb_addr, vb);
      chk(last_wb_data == expblk, "R5 writeback block", last_wb_data, expblk);
    end
    if (!we) chk(last_rd == gold[blk][wd], "R1 read data", last_rd, gold[blk][wd]);
    if (way < 0) begin
      way = v; stag[v][ix] = tg; sval[v][ix] = 1; sdirt[v][ix] = 0;
    end
    slru[ix] = 1 - way;
    if (we) begin sdirt[way][ix] = 1; gold[blk][wd] = wdat; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 global watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int b = 0; b < 32; b++)
      for (int w = 0; w < 4; w++) mem[b][w*32 +: 32] = 32'hA000_0000 + 32'(b*16 + w);
    do_reset();
    // R4: cold miss, clean
    access(0, 0, 0, 1, 0);
    chk(last_rf == 1 && last_wb == 0, "R4 cold miss", {last_rf, last_wb}, 1);
    // R2: hit
    access(0, 0, 0, 3, 0);
    chk(last_lat == 1 && last_rf == 0, "R2 read hit", last_lat, 1);
    // R3: write hit, no memory traffic
    access(1, 0, 0, 2, 32'h1234_5678);
    chk(last_rf == 0 && last_wb == 0, "R3 write hit no mem", {last_rf, last_wb}, 0);
    access(0, 0, 0, 2, 0);
    chk(last_rd == 32'h1234_5678, "R3 write hit data", last_rd, 32'h1234_5678);
    // R6: pointer follows use
    access(0, 1, 0, 0, 0);
    access(0, 0, 0, 0, 0);
    access(0, 2, 0, 0, 0);
    chk(last_wb == 0, "R6 clean victim B evicted", last_wb, 0);
    access(0, 0, 0, 1, 0);
    chk(last_rf == 0, "R6 recently used line kept", last_rf, 0);
    access(0, 1, 0, 0, 0);
    chk(last_rf == 1, "R6 victim line gone", last_rf, 1);
    // R5: dirty line 0 now victim (pointer after refill of tag1)
    access(0, 3, 0, 0, 0);
    chk(last_wb == 1 && last_wb_addr == 28'd0, "R5 dirty eviction", last_wb_addr, 0);
    chk(last_wb_data[95:64] == 32'h1234_5678, "R5 merged word", last_wb_data[95:64], 32'h1234_5678);
    // R7: write miss merge
    access(1, 4, 1, 1, 32'hCAFE_0001);
    chk(last_rf == 1, "R7 write miss refill", last_rf, 1);
    access(0, 5, 1, 0, 0);
    access(0, 6, 1, 0, 0);
    chk(last_wb == 1 && last_wb_data == {32'hA000_0000 + 32'(17*16+3), 32'hA000_0000 + 32'(17*16+2),
        32'hCAFE_0001, 32'hA000_0000 + 32'(17*16)}, "R7 merged writeback", last_wb_data, 0);
    // R8: reset discards dirty data
    access(1, 7, 2, 0, 32'hDEAD_BEEF);
    do_reset();
    access(0, 7, 2, 0, 0);
    chk(last_wb == 0 && last_rf == 1, "R8 reset invalidates", {last_wb, last_rf}, 1);
    chk(last_rd == 32'hA000_0000 + 32'(30*16), "R8 dirty data dropped", last_rd, 32'hA000_0000 + 32'(30*16));
    // sweep
    lf = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      access(lf[0], int'(lf[3:1]), int'(lf[5:4]), int'(lf[7:6]), {lf, ~lf});
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule